// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block is the transfer-side datapath of one DMA channel. Once it is loaded with a 16-bit start offset, an 8-bit page value, a 16-bit unit count, a channel width (byte or 16-bit word) and a transfer kind, it produces the 24-bit physical memory address of each transfer. On every accepted advance strobe it steps the offset up by one and the remaining count down by one. When the last unit has been moved it raises a terminal-count flag.

The offset counter is 16 bits wide and never carries into the page. A transfer therefore wraps inside its 64 KiB region, or its 128 KiB region on a word channel, instead of crossing into the next one. On a word channel the offset counter moves up one bit position, and the page value loses its lowest bit. The programmed count is one less than the number of units. The live count always shows the remaining units minus one. On each accepted advance, the transfer kind selects a memory-write strobe, a memory-read strobe, or no strobe at all for verify cycles.

A three-state sequencer controls the block. The states are `S_IDLE` (never loaded), `S_RUN` (transfer in progress) and `S_DONE` (terminal count reached). The transitions are:
- T_LOAD: any state moves to `S_RUN` on `load`.
- T_STEP: `S_RUN` stays in `S_RUN` on an advance while the count is non-zero.
- T_LAST: `S_RUN` moves to `S_DONE` on an advance while the count is zero.

Every other case holds the current state.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `phys_addr` = 0, `cur_count` = 0, `tc` = 0, `active` = 0 and both memory strobes are 0.
- R2: A `load` pulse captures offset, page, count, width and kind. From the next cycle, `active` = 1, `tc` = 0 and `cur_count` equals the loaded count. `load` takes priority over an `advance` in the same cycle.
- R3: On a byte channel (`load_word` = 0), `phys_addr[23:16]` is the page and `phys_addr[15:0]` is the offset counter.
- R4: On a word channel (`load_word` = 1), `phys_addr[23:17]` is page bits 7:1, `phys_addr[16:1]` is the offset counter and `phys_addr[0]` is 0. Page bit 0 has no effect.
- R5: An advance that is accepted (state `S_RUN`, `advance` = 1, `load` = 0) raises the offset counter by 1 and lowers `cur_count` by 1 in the next cycle.
- R6: The offset counter wraps from FFFFh to 0000h, and the page bits of `phys_addr` do not change.
- R7: The accepted advance taken while `cur_count` is 0 sets `tc` and leaves `cur_count` at FFFFh. A load of N therefore accepts exactly N+1 advances.
- R8: While `tc` is set and `load` is low, `advance` is ignored: `phys_addr` and `cur_count` hold and no strobe is driven.
- R9: During an accepted advance, kind 01 drives `mem_wr` = 1 and kind 10 drives `mem_rd` = 1, in the same cycle. Kind 00 (verify) and kind 11 drive neither strobe. No strobe is driven outside an accepted advance.
- R10: A load while `tc` is set clears `tc` and restarts the transfer with the new values.
- R11: Before the first load, `advance` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture a new transfer description |
| load_addr | input | 16 | Starting offset counter value |
| load_page | input | 8 | Page value for the upper address bits |
| load_count | input | 16 | Units to move minus one |
| load_word | input | 1 | 1 = 16-bit word channel, 0 = byte channel |
| load_kind | input | 2 | 00 verify, 01 write memory, 10 read memory, 11 none |
| advance | input | 1 | One transfer unit completed |
| phys_addr | output | 24 | Current physical memory address |
| cur_count | output | 16 | Remaining units minus one |
| tc | output | 1 | Terminal count reached |
| active | output | 1 | Transfer in progress and accepting advances |
| mem_wr | output | 1 | Memory write strobe for this advance |
| mem_rd | output | 1 | Memory read strobe for this advance |

## Verification
A bad offset or count register shows up on `phys_addr` or `cur_count` one cycle after the advance that corrupted it, because both outputs are plain register views. A wrong sequencer state is seen at once through `active`, `tc` and the strobes. It is also seen on the next advance, which either moves the counters when they should hold or holds them when they should move. Wrap and page-bit faults only appear when a transfer crosses FFFFh, so directed runs start just below that boundary on both channel widths.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    typedef enum logic [1:0] {
        XK_VERIFY = 2'b00,
        XK_MEM_WR = 2'b01,
        XK_MEM_RD = 2'b10,
        XK_NONE   = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_RUN  = 2'b01,
        S_DONE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/dma_ag_ctrl.sv
module dma_ag_ctrl
    import dma_ag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] load_kind,
    input  logic       advance,
    input  logic       count_zero,
    output logic       step,
    output logic       active,
    output logic       tc,
    output logic       mem_wr,
    output logic       mem_rd
);

    seq_state_e state_q, state_d;
    xfer_kind_e kind_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (load) state_d = S_RUN;
            S_RUN: begin
                if (load)                         state_d = S_RUN;
                else if (advance && count_zero)   state_d = S_DONE;
                else                              state_d = S_RUN;
            end
            S_DONE: if (load) state_d = S_RUN;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= XK_VERIFY;
        end else begin
            state_q <= state_d;
            if (load) kind_q <= xfer_kind_e'(load_kind);
        end
    end

    // outputs
    always_comb begin
        step   = 1'b0;
        active = 1'b0;
        tc     = 1'b0;
        mem_wr = 1'b0;
        mem_rd = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_RUN: begin
                active = 1'b1;
                step   = advance && !load;
                mem_wr = step && (kind_q == XK_MEM_WR);
                mem_rd = step && (kind_q == XK_MEM_RD);
            end
            S_DONE: tc = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_ag_addr_cnt.sv
module dma_ag_addr_cnt #(
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8,
    localparam int ADDR_W = CNT_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_addr,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              load_word,
    input  logic              step,
    output logic [ADDR_W-1:0] phys_addr
);

    logic [CNT_W-1:0]  ofs_q;
    logic [PAGE_W-1:0] page_q;
    logic              word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            page_q <= '0;
            word_q <= 1'b0;
        end else if (load) begin
            ofs_q  <= load_addr;
            page_q <= load_page;
            word_q <= load_word;
        end else if (step) begin
            ofs_q  <= ofs_q + 1'b1;   // wraps, never carries into page
        end
    end

    logic [ADDR_W-1:0] byte_map, word_map;
    assign byte_map = {page_q, ofs_q};
    assign word_map = {page_q[PAGE_W-1:1], ofs_q, 1'b0};

    always_comb phys_addr = word_q ? word_map : byte_map;

endmodule

// File: rtl/dma_ag_unit_cnt.sv
module dma_ag_unit_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             count_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= load_count;
        else if (step)    cnt_q <= cnt_q - 1'b1;
    end

    assign count      = cnt_q;
    assign count_zero = (cnt_q == '0);

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8,
    localparam int ADDR_W = CNT_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_addr,
    input  logic [PAGE_W-1:0] load_page,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              load_word,
    input  logic [1:0]        load_kind,
    input  logic              advance,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              tc,
    output logic              active,
    output logic              mem_wr,
    output logic              mem_rd
);

    logic step, count_zero;

    dma_ag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_kind  (load_kind),
        .advance    (advance),
        .count_zero (count_zero),
        .step       (step),
        .active     (active),
        .tc         (tc),
        .mem_wr     (mem_wr),
        .mem_rd     (mem_rd)
    );

    dma_ag_addr_cnt #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (load_addr),
        .load_page (load_page),
        .load_word (load_word),
        .step      (step),
        .phys_addr (phys_addr)
    );

    dma_ag_unit_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_count (load_count),
        .step       (step),
        .count      (cur_count),
        .count_zero (count_zero)
    );

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8,
    localparam int ADDR_W = CNT_W + PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              advance,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [CNT_W-1:0]  cur_count,
    input logic              tc,
    input logic              active,
    input logic              mem_wr,
    input logic              mem_rd
);

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && advance && !load) |=> (cur_count == $past(cur_count) - 1'b1));

    a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (active && advance && !load) |=> $stable(phys_addr[ADDR_W-1:CNT_W+1]));

    a_r7_tc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (active && advance && !load && cur_count == '0) |=> (tc && !active));

    a_r8_hold_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !load) |=> ($stable(phys_addr) && $stable(cur_count) && tc));

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    a_r9_strobe_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> (active && advance && !load));

    a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active && !tc));

endmodule

bind dma_addr_gen dma_addr_gen_chk #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .advance   (advance),
    .phys_addr (phys_addr),
    .cur_count (cur_count),
    .tc        (tc),
    .active    (active),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd)
);

// File: tb/dma_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_addr = '0;
    logic [7:0]  load_page = '0;
    logic [15:0] load_count = '0;
    logic        load_word = 1'b0;
    logic [1:0]  load_kind = '0;
    logic        advance = 1'b0;
    logic [23:0] phys_addr;
    logic [15:0] cur_count;
    logic        tc, active, mem_wr, mem_rd;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [15:0] m_ofs, m_cnt;
    logic [7:0]  m_page;
    logic        m_word;
    logic [1:0]  m_kind;
    int          m_state;   // 0 idle, 1 run, 2 done

    always #4 clk = ~clk;   // 125 MHz

    dma_addr_gen u_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
        .load_page(load_page), .load_count(load_count), .load_word(load_word),
        .load_kind(load_kind), .advance(advance), .phys_addr(phys_addr),
        .cur_count(cur_count), .tc(tc), .active(active),
        .mem_wr(mem_wr), .mem_rd(mem_rd)
    );

    function automatic logic [23:0] exp_addr();
        if (m_word) return {m_page[7:1], m_ofs, 1'b0};
        return {m_page, m_ofs};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check({req, " addr"},   phys_addr, exp_addr());
        check({req, " count"},  cur_count, m_cnt);
        check({req, " tc"},     tc, m_state == 2);
        check({req, " active"}, active, m_state == 1);
    endtask

    // one clock: drive, check strobes, clock, update model, check registers
    task automatic cycle(input logic ld, input logic [15:0] a, input logic [7:0] p,
                         input logic [15:0] c, input logic w, input logic [1:0] k,
                         input logic adv, input string req);
        logic acc;
        load = ld; load_addr = a; load_page = p; load_count = c;
        load_word = w; load_kind = k; advance = adv;
        #1;
        acc = (m_state == 1) && adv && !ld;
        check({req, " R9 wr"}, mem_wr, acc && m_kind == 2'b01);
        check({req, " R9 rd"}, mem_rd, acc && m_kind == 2'b10);
        @(posedge clk);
        if (ld) begin
            m_ofs = a; m_page = p; m_cnt = c; m_word = w; m_kind = k; m_state = 1;
        end else if (acc) begin
            m_ofs = m_ofs + 1;
            if (m_cnt == 0) m_state = 2;
            m_cnt = m_cnt - 1;
        end
        #1;
        check_regs(req);
    endtask

    task automatic adv_n(input int n, input string req);
        for (int i = 0; i < n; i++) cycle(0, '0, '0, '0, 0, 2'b00, 1, req);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_ofs = 0; m_cnt = 0; m_page = 0; m_word = 0; m_kind = 0; m_state = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check_regs("R1 reset");
        check("R1 wr", mem_wr, 0);
        check("R1 rd", mem_rd, 0);
        // R11 advance before any load
        adv_n(3, "R11 idle advance");
        // R2 R3 byte load, write kind
        cycle(1, 16'h1234, 8'h56, 16'd4, 0, 2'b01, 0, "R2 load byte");
        check("R3 byte map", phys_addr, 24'h561234);
        adv_n(2, "R5 byte step");
        check("R5 addr", phys_addr, 24'h561236);
        // R6 wrap on byte channel, read kind
        cycle(1, 16'hFFFE, 8'h12, 16'd3, 0, 2'b10, 0, "R2 reload");
        adv_n(3, "R6 byte wrap");
        check("R6 wrapped addr", phys_addr, 24'h120001);
        // R7 terminal count: one more advance uses the last unit
        adv_n(1, "R7 last");
        check("R7 tc", tc, 1);
        check("R7 count", cur_count, 16'hFFFF);
        // R8 advances ignored after tc
        adv_n(3, "R8 ignored");
        check("R8 addr held", phys_addr, 24'h120002);
        // R4 word channel, page bit0 ignored, R10 load clears tc
        cycle(1, 16'hFFFF, 8'h35, 16'd1, 1, 2'b00, 0, "R10 load after tc");
        check("R4 word map", phys_addr, 24'h35FFFE);
        adv_n(1, "R6 word wrap");
        check("R6 word wrapped", phys_addr, 24'h340000);
        adv_n(1, "R7 word last");
        check("R7 word tc", tc, 1);
        // R2 load wins over advance; kind 11 no strobes
        cycle(1, 16'h0010, 8'h01, 16'd0, 0, 2'b11, 1, "R2 load priority");
        check("R2 not stepped", phys_addr, 24'h010010);
        adv_n(1, "R9 kind11");
        // random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2000; i++) begin
            logic ld;
            logic [15:0] c;
            ld = ($urandom % 16) == 0;
            c  = (($urandom % 8) == 0) ? 16'($urandom) : 16'($urandom % 24);
            cycle(ld, 16'hFFF0 | 16'($urandom % 16), 8'($urandom), c, 1'($urandom),
                  2'($urandom), 1'($urandom), "R5 R7 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule